// File: doc/BRIEF.md
# Shared-Pointer Indirect Register Access Port

This block is a host I/O slave that reaches two internal register banks, a control-status bank and a bus-configuration bank, through a single index register. The host first writes the index register through its own port. It then reads or writes a data port that belongs to one bank. Because both data ports use the same index, the host can load the index once and then touch the same-numbered entry in either bank without reloading it.

A mode input selects word (16-bit) or double-word (32-bit) I/O. The mode moves the index port and the bus-configuration data port to different offsets. Reads are combinational and appear on the read bus while the read strobe is high. Writes take effect at the next rising clock edge.

A hard reset (asynchronous, active low, released in step with the clock) clears everything. A soft reset clears only the index. A stop input is accepted but leaves the index alone.

Top module: `indirect_reg_port`

## Requirements
- R1: A write to the index port loads wr_data[7:0] into the 8-bit index. A read of the index port returns the index in bits 7:0 and zero in bits 31:8.
- R2: In word mode (dword_mode = 0), the control-status data port is at offset 10h, the index port at 12h and the bus-configuration data port at 16h.
- R3: In double-word mode (dword_mode = 1), the control-status data port is at offset 10h, the index port at 14h and the bus-configuration data port at 1Ch.
- R4: One index value selects entry [index] in both banks. The two banks hold separate storage, so a write through one data port never changes the other bank.
- R5: A data-port write stores wr_data[15:0]. A data-port read returns the stored 16-bit value with bits 31:16 at zero, in both modes.
- R6: While rst_n is low, the index and every entry of both banks read as zero after release.
- R7: When soft_rst is high at a rising edge, the index becomes zero, even if an index write happens in the same cycle. Bank contents are kept.
- R8: The stop input has no effect on the index.
- R9: Indexes 8 and above (beyond the default 8 entries) are not implemented. Writes to them are discarded and reads from them return zero.
- R10: An access to an offset that matches no port in the current mode is ignored on write and returns zero on read.
- R11: While rd_en is low, rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, clears the index at a rising edge |
| stop | input | 1 | Stop request, has no effect on the index |
| dword_mode | input | 1 | 0 selects word I/O, 1 selects double-word I/O |
| io_addr | input | 5 | I/O byte offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid while rd_en is high |

## Verification
The assertions assume three things about the inputs. Only one of rd_en and wr_en is high in a cycle. The strobes, offset and mode stay steady from one falling edge to the next. soft_rst and stop are never high during hard reset.

The stimulus follows these rules. It changes every input at a falling edge and samples the combinational read bus two nanoseconds later. It raises at most one strobe per step. It drives soft_rst and stop only in directed steps, well after the synchronized reset release.

// File: rtl/iport_pkg.sv
package iport_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_IDX  = 2'd1,
    SEL_CSR  = 2'd2,
    SEL_BCR  = 2'd3
  } port_sel_e;

  // Byte offsets; the mode-dependent ones come in word / double-word pairs
  localparam logic [4:0] OFS_CSR     = 5'h10;
  localparam logic [4:0] OFS_IDX_WRD = 5'h12;
  localparam logic [4:0] OFS_IDX_DWD = 5'h14;
  localparam logic [4:0] OFS_BCR_WRD = 5'h16;
  localparam logic [4:0] OFS_BCR_DWD = 5'h1C;

endpackage

// File: rtl/iport_decode.sv
module iport_decode
  import iport_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              dword_mode,
  output port_sel_e         sel
);

  logic [ADDR_W-1:0] idx_ofs;
  logic [ADDR_W-1:0] bcr_ofs;

  always_comb begin
    idx_ofs = dword_mode ? ADDR_W'(OFS_IDX_DWD) : ADDR_W'(OFS_IDX_WRD);
    bcr_ofs = dword_mode ? ADDR_W'(OFS_BCR_DWD) : ADDR_W'(OFS_BCR_WRD);
  end

  always_comb begin
    sel = SEL_NONE;
    if (io_addr == ADDR_W'(OFS_CSR)) begin
      sel = SEL_CSR;
    end else if (io_addr == idx_ofs) begin
      sel = SEL_IDX;
    end else if (io_addr == bcr_ofs) begin
      sel = SEL_BCR;
    end
  end

endmodule

// File: rtl/iport_pointer.sv
module iport_pointer #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             load,
  input  logic [PTR_W-1:0] din,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_nxt;
  logic             ptr_en;

  always_comb begin
    ptr_en  = soft_rst | load;
    ptr_nxt = soft_rst ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_en) begin
      ptr <= ptr_nxt;
    end
  end

  // R7: soft reset wins over a same-cycle load
  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ptr == '0));

  // R1: a plain load captures the presented byte
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !soft_rst) |=> (ptr == $past(din)));

endmodule

// File: rtl/iport_bank.sv
module iport_bank #(
  parameter int N_REGS = 8,
  parameter int REG_W  = 16,
  parameter int IDX_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] dout
);

  localparam int SLOT_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

  logic [REG_W-1:0]        mem [N_REGS];
  logic [N_REGS*REG_W-1:0] mem_flat;
  logic                    hit;
  logic [SLOT_W-1:0]       slot;

  always_comb begin
    hit  = (int'(idx) < N_REGS);
    slot = idx[SLOT_W-1:0];
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_slot
    logic ent_en;
    assign ent_en = we && hit && (slot == SLOT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (ent_en) begin
        mem[i] <= din;
      end
    end

    assign mem_flat[i*REG_W +: REG_W] = mem[i];
  end

  always_comb begin
    dout = '0;
    if (hit) begin
      dout = mem[slot];
    end
  end

  // R9: a write to an unimplemented index leaves every entry untouched
  assert_oob_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (int'(idx) >= N_REGS)) |=> $stable(mem_flat));

  // R4: no write request, no storage change
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_flat));

endmodule

// File: rtl/indirect_reg_port.sv
module indirect_reg_port
  import iport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8,
  parameter int REG_W  = 16,
  parameter int N_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              dword_mode,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic             rst_meta;
  logic             rst_sync;
  port_sel_e        sel;
  logic [PTR_W-1:0] ptr;
  logic             ptr_load;
  logic             csr_we;
  logic             bcr_we;
  logic [REG_W-1:0] csr_dout;
  logic [REG_W-1:0] bcr_dout;
  logic             unused_inputs;

  assign unused_inputs = ^{stop, wr_data[DATA_W-1:REG_W]};

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  iport_decode #(.ADDR_W(ADDR_W)) u_decode (
    .io_addr    (io_addr),
    .dword_mode (dword_mode),
    .sel        (sel)
  );

  always_comb begin
    ptr_load = wr_en && (sel == SEL_IDX);
    csr_we   = wr_en && (sel == SEL_CSR);
    bcr_we   = wr_en && (sel == SEL_BCR);
  end

  iport_pointer #(.PTR_W(PTR_W)) u_pointer (
    .clk      (clk),
    .rst_n    (rst_sync),
    .soft_rst (soft_rst),
    .load     (ptr_load),
    .din      (wr_data[PTR_W-1:0]),
    .ptr      (ptr)
  );

  iport_bank #(.N_REGS(N_REGS), .REG_W(REG_W), .IDX_W(PTR_W)) u_csr_bank (
    .clk   (clk),
    .rst_n (rst_sync),
    .we    (csr_we),
    .idx   (ptr),
    .din   (wr_data[REG_W-1:0]),
    .dout  (csr_dout)
  );

  iport_bank #(.N_REGS(N_REGS), .REG_W(REG_W), .IDX_W(PTR_W)) u_bcr_bank (
    .clk   (clk),
    .rst_n (rst_sync),
    .we    (bcr_we),
    .idx   (ptr),
    .din   (wr_data[REG_W-1:0]),
    .dout  (bcr_dout)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_IDX:  rd_data = DATA_W'(ptr);
        SEL_CSR:  rd_data = DATA_W'(csr_dout);
        SEL_BCR:  rd_data = DATA_W'(bcr_dout);
        default:  rd_data = '0;
      endcase
    end
  end

  // R11: bus is quiet without a read strobe
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    !rd_en |-> (rd_data == '0));

  // R5: upper half of a read is always zero
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    rd_en |-> (rd_data[DATA_W-1:REG_W] == '0));

  // R10: a write to no port leaves the index alone
  assert_unmatched_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_en && (sel == SEL_NONE) && !soft_rst) |=> $stable(ptr));

  // R8: stop with no write and no soft reset leaves the index alone
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    (stop && !wr_en && !soft_rst) |=> $stable(ptr));

endmodule

// File: tb/test_indirect_reg_port.sv
module test_indirect_reg_port;

  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_WR   = 2'd1;
  localparam logic [1:0] OP_RD   = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic        dw;
    logic [4:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   1'b0, 5'h12, 32'h0000_0000},  // R6 index after reset
    '{OP_WR,   1'b0, 5'h12, 32'hFFFF_FF03},  // R1
    '{OP_RD,   1'b0, 5'h12, 32'h0000_0003},  // R1 upper bits zero
    '{OP_WR,   1'b0, 5'h10, 32'hABCD_1234},  // R5
    '{OP_WR,   1'b0, 5'h16, 32'h0000_5678},  // R2
    '{OP_RD,   1'b0, 5'h10, 32'h0000_1234},  // R4 R5
    '{OP_RD,   1'b0, 5'h16, 32'h0000_5678},  // R2 R4
    '{OP_RD,   1'b1, 5'h14, 32'h0000_0003},  // R3
    '{OP_RD,   1'b1, 5'h1C, 32'h0000_5678},  // R3
    '{OP_RD,   1'b1, 5'h10, 32'h0000_1234},  // R3
    '{OP_WR,   1'b1, 5'h14, 32'h0000_0005},  // R3
    '{OP_WR,   1'b1, 5'h1C, 32'hFFFF_BEEF},  // R5
    '{OP_RD,   1'b1, 5'h1C, 32'h0000_BEEF},  // R5 zero-extended
    '{OP_RD,   1'b1, 5'h10, 32'h0000_0000},  // R4 other bank untouched
    '{OP_RD,   1'b0, 5'h14, 32'h0000_0000},  // R10 14h unmatched in word mode
    '{OP_WR,   1'b0, 5'h1C, 32'h0000_1111},  // R10
    '{OP_RD,   1'b1, 5'h1C, 32'h0000_BEEF},  // R10 write was ignored
    '{OP_RD,   1'b1, 5'h12, 32'h0000_0000},  // R10 12h unmatched in dword mode
    '{OP_RD,   1'b0, 5'h16, 32'h0000_BEEF},  // R2
    '{OP_WR,   1'b0, 5'h12, 32'h0000_000A},  // R9
    '{OP_WR,   1'b0, 5'h10, 32'h0000_7777},  // R9
    '{OP_RD,   1'b0, 5'h10, 32'h0000_0000},  // R9 read zero
    '{OP_WR,   1'b0, 5'h12, 32'h0000_0002},  // R9
    '{OP_RD,   1'b0, 5'h10, 32'h0000_0000},  // R9 no alias into slot 2
    '{OP_WR,   1'b0, 5'h00, 32'h0000_0009},  // R10
    '{OP_RD,   1'b0, 5'h12, 32'h0000_0002},  // R10 index kept
    '{OP_WR,   1'b0, 5'h12, 32'h0000_00FF},  // R1
    '{OP_RD,   1'b1, 5'h14, 32'h0000_00FF},  // R1 full byte
    '{OP_IDLE, 1'b0, 5'h10, 32'h0000_0000}   // R11
  };

  logic        clk;
  logic        rst_n;
  logic        soft_rst;
  logic        stop;
  logic        dword_mode;
  logic [4:0]  io_addr;
  logic        rd_en;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  int n_chk;
  int n_bad;
  bit done;

  indirect_reg_port i_indirect_reg_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .stop       (stop),
    .dword_mode (dword_mode),
    .io_addr    (io_addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [31:0] exp, input string tag);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data actual %08h expected %08h", tag, rd_data, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic dw, input logic [4:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    dword_mode = dw;
    io_addr    = a;
    wr_en      = (op == OP_WR);
    rd_en      = (op == OP_RD);
    wr_data    = (op == OP_WR) ? d : 32'h0;
    #2;
    if (op != OP_WR) check(d, tag);
  endtask

  task automatic quiet();
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    wr_data = 32'h0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; soft_rst = 1'b0; stop = 1'b0; dword_mode = 1'b0;
    io_addr = 5'h0; rd_en = 1'b0; wr_en = 1'b0; wr_data = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      step(VECS[k].op, VECS[k].dw, VECS[k].addr, VECS[k].data,
           $sformatf("vector %0d", k));
    end
    quiet();

    // R8: stop held for several cycles leaves the index at FFh
    stop = 1'b1;
    repeat (4) @(negedge clk);
    step(OP_RD, 1'b0, 5'h12, 32'h0000_00FF, "R8 stop hold");
    stop = 1'b0;

    // R7: soft reset beats a same-cycle index write
    step(OP_WR, 1'b0, 5'h12, 32'h0000_0003, "R7 setup");
    @(negedge clk);
    soft_rst = 1'b1; wr_en = 1'b1; rd_en = 1'b0; io_addr = 5'h12; wr_data = 32'h6;
    @(negedge clk);
    soft_rst = 1'b0; wr_en = 1'b0;
    step(OP_RD, 1'b0, 5'h12, 32'h0000_0000, "R7 index cleared");
    step(OP_WR, 1'b0, 5'h12, 32'h0000_0003, "R7 reload");
    step(OP_RD, 1'b0, 5'h10, 32'h0000_1234, "R7 bank kept");
    quiet();

    // R6: hard reset clears index and banks
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(OP_RD, 1'b0, 5'h12, 32'h0000_0000, "R6 index");
    step(OP_WR, 1'b0, 5'h12, 32'h0000_0003, "R6 setup");
    step(OP_RD, 1'b0, 5'h10, 32'h0000_0000, "R6 control bank");
    step(OP_RD, 1'b0, 5'h16, 32'h0000_0000, "R6 config bank");
    quiet();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule